// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Controller

This block is the hart-facing stage of a platform interrupt controller that works in direct wired mode. A separate source bank supplies one bit per interrupt source. That bit means the source is active, pending and enabled. For each source, this block stores a target word that names a destination hart and a priority number. For every implemented hart it keeps a small register window: a delivery enable, a force bit and a priority threshold. Two read-only views complete the window: a top-interrupt value and a claim value.

For each hart, the block picks the most urgent eligible source. A lower priority number is more urgent, and equal numbers go to the lower source ID. It then filters that source against the hart's threshold and drives one external-interrupt line per hart. The line is also gated by the domain-wide enable input. A claim read returns the chosen source and pulses a one-cycle clear request for that source back to the source bank. Software repeats claim reads until it reads zero.

Top module: `hart_irq_deliver`

## Requirements
- R1: Hart h owns a 32-byte window at byte address 0x4000 + 32*h. Delivery enable is bit 0 at offset 0x00, force is bit 0 at offset 0x04 and the threshold is bits 7:0 at offset 0x08. A written value reads back; unused bits read 0.
- R2: Source s (1..NUM_SRC) has a target word at 0x3004 + 4*(s-1), with the hart index in bits 31:18 and the priority in bits 7:0. A priority written as 0 is stored as 1.
- R3: The top value (offset 0x18) is {source ID in bits 25:16, priority in bits 7:0}, with all other bits 0. The source is the eligible one with the lowest priority number, and the lower ID wins a tie. The value is 0 when no source is eligible.
- R4: With a nonzero threshold T, only sources whose priority is strictly below T are eligible. A threshold of 0 filters nothing, and a threshold of 1 blocks every source.
- R5: A source is eligible only for the hart named in its target word. A hart index of NUM_HART or above reaches no hart.
- R6: A claim read (offset 0x1C) returns the same value as the top view. When that value is nonzero, the block pulses bit s-1 of claim_clr_o for exactly the one cycle after the read. Reads of the top view, and claim reads that return 0, pulse nothing.
- R7: irq_o[h] is high exactly when domain_ie_i is high, the delivery enable of hart h is 1, and either hart h has an eligible source or its force bit is 1.
- R8: Force raises the hart line even with nothing pending; the top view then reads 0. A claim read that returns 0 clears force.
- R9: After reset, every threshold, enable and force is 0, every target word reads hart 0 with priority 1, irq_o is 0 and rdata_o is 0.
- R10: rdata_o takes the read value at the clock edge that samples a read and holds it otherwise. An unmapped or misaligned address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| domain_ie_i | input | 1 | Domain-wide interrupt enable |
| pend_i | input | NUM_SRC | Active, pending and enabled bits; bit s-1 belongs to source s |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| claim_clr_o | output | NUM_SRC | One-cycle clear request for the claimed source |
| irq_o | output | NUM_HART | External-interrupt line per hart |

## Verification
The assertions check properties that hold on every cycle. The hart lines stay low while the domain enable is low. The clear request is one-hot or zero, follows a read cycle, and names only a source that was pending on that read. The read data holds steady between reads. The bench scenarios are the only way to show which source wins under a given mix of priorities, ties, thresholds and target harts. They also cover the exact read values, and the drain order of successive claims together with the one-shot clearing of force.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned HIDX_W = 14;
  localparam int unsigned HIDX_LSB = 18;

  localparam logic [31:0] TGT_BASE  = 32'h0000_3004;
  localparam logic [31:0] WIN_BASE  = 32'h0000_4000;
  localparam int unsigned WIN_SHIFT = 5;

  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  function automatic logic [31:0] pack_top(input logic [ID_W-1:0] id,
                                           input logic [PRIO_W-1:0] prio);
    return {6'b0, id, 8'b0, prio};
  endfunction
endpackage

// File: rtl/hid_src_table.sv
module hid_src_table
  import hid_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12,
  localparam int unsigned SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [SIDX_W-1:0]                 idx_i,
  input  logic [31:0]                       wdata_i,
  output logic [NUM_SRC-1:0][HIDX_W-1:0]    hart_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_o,
  output logic [31:0]                       rdata_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hart_o[s] <= '0;
        prio_o[s] <= PRIO_W'(1);
      end else if (wr_i && idx_i == SIDX_W'(s)) begin
        hart_o[s] <= wdata_i[HIDX_LSB +: HIDX_W];
        // priority 0 is not a legal level
        prio_o[s] <= (wdata_i[PRIO_W-1:0] == '0) ? PRIO_W'(1) : wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (idx_i == SIDX_W'(s)) rdata_o = {hart_o[s], 10'b0, prio_o[s]};
    end
  end
endmodule

// File: rtl/hid_hart_ctx.sv
module hid_hart_ctx
  import hid_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned HART_IDX = 0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sel_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [4:0]                     off_i,
  input  logic [31:0]                    wdata_i,
  input  logic                           gate_i,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][HIDX_W-1:0] src_hart_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio_i,
  output logic [31:0]                    rdata_o,
  output logic [NUM_SRC-1:0]             claim_o,
  output logic                           irq_o
);
  logic              deliv_q, force_q;
  logic [PRIO_W-1:0] thr_q;

  logic              best_vld;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic [NUM_SRC-1:0] best_oh;
  logic [31:0]       top_val;
  logic              claim_rd;

  // ascending scan with strict compare: ties keep the lower ID
  always_comb begin
    best_vld  = 1'b0;
    best_id   = '0;
    best_prio = '1;
    best_oh   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (pend_i[s] && src_hart_i[s] == HIDX_W'(HART_IDX) &&
          (thr_q == '0 || src_prio_i[s] < thr_q) &&
          (!best_vld || src_prio_i[s] < best_prio)) begin
        best_vld  = 1'b1;
        best_id   = ID_W'(s + 1);
        best_prio = src_prio_i[s];
        best_oh   = '0;
        best_oh[s] = 1'b1;
      end
    end
  end

  assign top_val  = best_vld ? pack_top(best_id, best_prio) : 32'h0;
  assign claim_rd = sel_i && rd_i && off_i == OFF_CLAIM;
  assign claim_o  = claim_rd ? best_oh : '0;
  assign irq_o    = gate_i && deliv_q && (best_vld || force_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      if (sel_i && wr_i) begin
        unique case (off_i)
          OFF_DELIV: deliv_q <= wdata_i[0];
          OFF_FORCE: force_q <= wdata_i[0];
          OFF_THR:   thr_q   <= wdata_i[PRIO_W-1:0];
          default: ;
        endcase
      end
      if (claim_rd && !best_vld) force_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_DELIV: rdata_o = {31'b0, deliv_q};
      OFF_FORCE: rdata_o = {31'b0, force_q};
      OFF_THR:   rdata_o = {{(32-PRIO_W){1'b0}}, thr_q};
      OFF_TOP,
      OFF_CLAIM: rdata_o = top_val;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned NUM_HART = 3,
  parameter int unsigned ADDR_W   = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                domain_ie_i,
  input  logic [NUM_SRC-1:0]  pend_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_SRC-1:0]  claim_clr_o,
  output logic [NUM_HART-1:0] irq_o
);
  localparam int unsigned SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [31:0] TGT_END = TGT_BASE + 32'(4 * NUM_SRC);
  localparam logic [31:0] WIN_END = WIN_BASE + 32'(NUM_HART << WIN_SHIFT);

  logic [31:0] a32, tgt_ofs, win_ofs;
  logic        tgt_hit, win_hit, rd, wr;
  logic [NUM_HART-1:0] hsel;

  logic [NUM_SRC-1:0][HIDX_W-1:0] src_hart;
  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
  logic [31:0]                    tbl_rd;
  logic [NUM_HART-1:0][31:0]      ctx_rd;
  logic [NUM_HART-1:0][NUM_SRC-1:0] ctx_claim;
  logic [NUM_SRC-1:0]             claim_any;
  logic [31:0]                    rdata_d;

  assign a32     = 32'(addr_i);
  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;
  assign tgt_ofs = a32 - TGT_BASE;
  assign win_ofs = a32 - WIN_BASE;
  assign tgt_hit = a32[1:0] == 2'b00 && a32 >= TGT_BASE && a32 < TGT_END;
  assign win_hit = a32[1:0] == 2'b00 && a32 >= WIN_BASE && a32 < WIN_END;

  always_comb begin
    for (int h = 0; h < NUM_HART; h++)
      hsel[h] = win_hit && (win_ofs >> WIN_SHIFT) == 32'(h);
  end

  hid_src_table #(.NUM_SRC(NUM_SRC)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && tgt_hit),
    .idx_i   (SIDX_W'(tgt_ofs >> 2)),
    .wdata_i (wdata_i),
    .hart_o  (src_hart),
    .prio_o  (src_prio),
    .rdata_o (tbl_rd)
  );

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    hid_hart_ctx #(.NUM_SRC(NUM_SRC), .HART_IDX(h)) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (hsel[h]),
      .wr_i       (wr),
      .rd_i       (rd),
      .off_i      (addr_i[4:0]),
      .wdata_i    (wdata_i),
      .gate_i     (domain_ie_i),
      .pend_i     (pend_i),
      .src_hart_i (src_hart),
      .src_prio_i (src_prio),
      .rdata_o    (ctx_rd[h]),
      .claim_o    (ctx_claim[h]),
      .irq_o      (irq_o[h])
    );
  end

  always_comb begin
    claim_any = '0;
    rdata_d   = tgt_hit ? tbl_rd : 32'h0;
    for (int h = 0; h < NUM_HART; h++) begin
      claim_any = claim_any | ctx_claim[h];
      if (hsel[h]) rdata_d = ctx_rd[h];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      claim_clr_o <= '0;
    end else begin
      if (rd) rdata_o <= rdata_d;
      claim_clr_o <= claim_any;
    end
  end
endmodule

// File: rtl/hart_irq_deliver_chk.sv
module hart_irq_deliver_chk #(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned NUM_HART = 3,
  parameter int unsigned ADDR_W   = 15
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                domain_ie_i,
  input logic [NUM_SRC-1:0]  pend_i,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_SRC-1:0]  claim_clr_o,
  input logic [NUM_HART-1:0] irq_o
);
  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !domain_ie_i |-> irq_o == '0);

  assert_clr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_clr_o));

  assert_clr_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_clr_o != '0) |-> $past(req_i && !we_i));

  assert_clr_was_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_clr_o != '0) |-> ((claim_clr_o & ~$past(pend_i)) == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> $stable(rdata_o));
endmodule

bind hart_irq_deliver hart_irq_deliver_chk #(
  .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_hart_irq_deliver.sv
module tb_hart_irq_deliver;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 12;
  localparam int NH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dom_ie = 1'b0;
  logic [NS-1:0] pend = '0;
  logic req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NS-1:0] clr;
  logic [NH-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_irq_deliver #(.NUM_SRC(NS), .NUM_HART(NH), .ADDR_W(15)) dut (
    .clk_i(clk), .rst_ni(rst_n), .domain_ie_i(dom_ie), .pend_i(pend),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .claim_clr_o(clr), .irq_o(irq)
  );

  // {pend, threshold(hart0), expected top value}
  localparam logic [51:0] VECS [0:11] = '{
    {12'h001, 8'd0,  32'h0001_0005},
    {12'h003, 8'd0,  32'h0002_0003},
    {12'h006, 8'd0,  32'h0002_0003},
    {12'h024, 8'd0,  32'h0006_0002},
    {12'h009, 8'd6,  32'h0001_0005},
    {12'h008, 8'd9,  32'h0000_0000},
    {12'h008, 8'd10, 32'h0004_0009},
    {12'h00B, 8'd1,  32'h0000_0000},
    {12'h010, 8'd0,  32'h0000_0000},
    {12'h040, 8'd0,  32'h0000_0000},
    {12'h0A0, 8'd0,  32'h0008_0001},
    {12'h000, 8'd0,  32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  // claim read; the bench's source bank drops the bit that was cleared
  task automatic claim(input logic [14:0] a, output logic [31:0] d, output logic [NS-1:0] c);
    rd(a, d);
    c = clr;
    pend = pend & ~clr;
    @(negedge clk);
  endtask

  function automatic logic [14:0] tgt(input int s);
    return 15'(32'h3004 + 4 * (s - 1));
  endfunction

  function automatic logic [14:0] win(input int h, input logic [4:0] off);
    return 15'(32'h4000 + 32 * h + off);
  endfunction

  initial begin
    logic [31:0] v;
    logic [NS-1:0] c;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 irq", 32'(irq), 32'h0);
    chk("R9 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd(tgt(1), v);        chk("R9 target default", v, 32'h0000_0001);
    rd(win(0, 5'h08), v); chk("R9 threshold", v, 32'h0);
    rd(win(1, 5'h00), v); chk("R9 deliv", v, 32'h0);

    // R1 window layout and readback
    wr(win(2, 5'h08), 32'hFFFF_FFAB);
    rd(win(2, 5'h08), v); chk("R1 threshold readback", v, 32'h0000_00AB);
    wr(win(1, 5'h00), 32'hFFFF_FFFF);
    rd(win(1, 5'h00), v); chk("R1 deliv readback", v, 32'h1);
    wr(win(2, 5'h08), 32'h0);

    // R2 target programming
    wr(tgt(1), 32'd5);
    wr(tgt(2), 32'd3);
    wr(tgt(3), 32'd3);
    wr(tgt(4), 32'd9);
    wr(tgt(5), (32'd1 << 18) | 32'd0);
    wr(tgt(6), 32'd2);
    wr(tgt(7), (32'd5 << 18) | 32'd2);
    rd(tgt(5), v); chk("R2 zero prio stored as 1", v, 32'h0004_0001);
    rd(tgt(7), v); chk("R2 hart field", v, 32'h0014_0002);

    dom_ie = 1'b1;
    wr(win(0, 5'h00), 32'h1);

    // R3 R4 R5 vector walk on hart 0
    for (int i = 0; i < 12; i++) begin
      pend = VECS[i][51:40];
      wr(win(0, 5'h08), 32'(VECS[i][39:32]));
      rd(win(0, 5'h18), v);
      chk($sformatf("R3 R4 R5 vec%0d top", i), v, VECS[i][31:0]);
      chk($sformatf("R7 vec%0d irq0", i), 32'(irq[0]), 32'(VECS[i][31:0] != 0));
      chk($sformatf("R6 vec%0d top read no clear", i), 32'(clr), 32'h0);
    end

    // R5 hart 1 sees its own source
    pend = 12'h010;
    rd(win(1, 5'h18), v); chk("R5 hart1 top", v, 32'h0005_0001);
    chk("R7 hart1 irq", 32'(irq[1]), 32'h1);

    // R7 gating
    pend = 12'h001;
    @(negedge clk); chk("R7 irq0 on", 32'(irq[0]), 32'h1);
    dom_ie = 1'b0;
    @(negedge clk); chk("R7 domain gate", 32'(irq), 32'h0);
    dom_ie = 1'b1;
    wr(win(0, 5'h00), 32'h0);
    chk("R7 deliv gate", 32'(irq[0]), 32'h0);
    wr(win(0, 5'h00), 32'h1);

    // R6 claim drain
    pend = 12'h003;
    claim(win(0, 5'h1C), v, c);
    chk("R6 claim1 value", v, 32'h0002_0003);
    chk("R6 claim1 clear", 32'(c), 32'h002);
    claim(win(0, 5'h1C), v, c);
    chk("R6 claim2 value", v, 32'h0001_0005);
    chk("R6 claim2 clear", 32'(c), 32'h001);
    claim(win(0, 5'h1C), v, c);
    chk("R6 claim empty value", v, 32'h0);
    chk("R6 claim empty clear", 32'(c), 32'h0);
    chk("R7 irq0 after drain", 32'(irq[0]), 32'h0);

    // R8 force on hart 2
    wr(win(2, 5'h00), 32'h1);
    wr(win(2, 5'h04), 32'h1);
    chk("R8 forced irq", 32'(irq[2]), 32'h1);
    rd(win(2, 5'h18), v); chk("R8 forced top zero", v, 32'h0);
    claim(win(2, 5'h1C), v, c);
    chk("R8 claim zero", v, 32'h0);
    rd(win(2, 5'h04), v); chk("R8 force cleared", v, 32'h0);
    chk("R8 irq dropped", 32'(irq[2]), 32'h0);

    // R10 unmapped, misaligned, hold
    rd(15'h0100, v); chk("R10 unmapped", v, 32'h0);
    rd(15'h3006, v); chk("R10 misaligned", v, 32'h0);
    rd(tgt(4), v);
    wr(win(0, 5'h08), 32'h7);
    @(negedge clk); chk("R10 hold over write", rdata, 32'h0000_0009);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule